// File: doc/BRIEF.md
# RTC Periodic Tick Timer

This block produces the periodic tick interrupt of a real-time clock peripheral. A 32768 Hz enable pulse drives a free-running prescaler. A 4-bit select field in the control word picks the rate at which a down counter steps: the source rate divided by two to the power of that field. The counter starts from a programmed reload count. Each time it expires it raises a tick pending flag, drives the tick interrupt line, reloads itself and keeps running.

Software reaches four word registers through single-cycle write strobes and a combinational read port. Reads have no side effects. The registers are:

- a write-one-to-clear pending register, shared with an alarm flag that an external alarm pulse sets;
- the control word;
- the reload count;
- a read-only live count.

The counter starts only on a 0-to-1 change of the tick enable, written while the global enable is set and the reload count is nonzero. It stops when either enable is cleared.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset, all four registers read 0 and both interrupt lines are low.
- R2: A write to the reload register (address 2) with a value of 2 or less leaves the stored value unchanged. A larger value is stored and reads back.
- R3: A control write (address 1) starts the counter and loads the live count with the reload count only when all of these hold: it sets bit 0 (global enable), it sets bit 8 (tick enable) while the stored bit 8 was 0, and the stored reload count is nonzero. Any other control write does not start the counter.
- R4: While running, the live count steps once for every 2^N source pulses, where N is control bits [7:4]. The step falls on the pulse whose 1-based index since reset is a multiple of 2^N.
- R5: On the step taken when the live count is 1, the count reloads, pending bit 0 sets and the tick interrupt rises, so one tick period is reload-count steps. Counting continues.
- R6: A write to the pending register (address 0) clears bit 0 and lowers the tick interrupt where the written bit 0 is 1. It clears bit 1 and lowers the alarm interrupt where the written bit 1 is 1. Zero bits leave their flags unchanged.
- R7: Clearing control bit 0, or clearing bit 8 while bit 0 stays set, stops the counter. The live count then holds its value and no tick is raised.
- R8: A pulse on the alarm input sets pending bit 1 and raises the alarm interrupt.
- R9: The live count is read at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_en | input | 1 | 32768 Hz enable pulse, one clock wide |
| alarm_set | input | 1 | Alarm event pulse that sets pending bit 1 |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register select: 0 pending, 1 control, 2 reload, 3 live count |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected register |
| irq_tick | output | 1 | Tick interrupt, follows pending bit 0 |
| irq_alarm | output | 1 | Alarm interrupt, follows pending bit 1 |

## Verification
The expiry and clear properties exclude cycles with a control write, because a stop or restart in the same cycle takes priority. The properties assume that written reload values fit the counter width. The stimulus never drives a source pulse in the same cycle as a register write. It keeps every reload value below the counter width. It resets the design before each sweep point so that the prescaler phase is known, and the expected step instants are then computed from the pulse count.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  typedef enum logic [1:0] {
    REG_PEND   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_RELOAD = 2'd2,
    REG_LIVE   = 2'd3
  } reg_sel_e;

  localparam int CTRL_W     = 9;
  localparam int GEN_BIT    = 0;
  localparam int SEL_LSB    = 4;
  localparam int SEL_W      = 4;
  localparam int TICK_BIT   = 8;
  localparam int PEND_W     = 2;
  localparam int RELOAD_MIN = 2;
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
  parameter int PRE_W = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe_o
);
  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel));
    strobe_o = src_en && ((pre_q & mask) == mask);
    pre_d    = src_en ? pre_q + 1'b1 : pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic              expire,
  input  logic              alarm_set,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [PEND_W-1:0] pend_o,
  output logic              start_o,
  output logic              stop_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d, new_ctrl;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [PEND_W-1:0] pend_q, pend_d, clr;
  logic              wr_ctrl, wr_reload, wr_pend;

  always_comb begin
    wr_ctrl   = wr_en && (addr == REG_CTRL);
    wr_reload = wr_en && (addr == REG_RELOAD);
    wr_pend   = wr_en && (addr == REG_PEND);
    new_ctrl  = wdata[CTRL_W-1:0];

    start_o = wr_ctrl && new_ctrl[GEN_BIT] && new_ctrl[TICK_BIT] &&
              !ctrl_q[TICK_BIT] && (reload_q != '0);
    stop_o  = wr_ctrl && ((ctrl_q[GEN_BIT] && !new_ctrl[GEN_BIT]) ||
              (new_ctrl[GEN_BIT] && ctrl_q[TICK_BIT] && !new_ctrl[TICK_BIT]));

    ctrl_d   = wr_ctrl ? new_ctrl : ctrl_q;
    reload_d = (wr_reload && (wdata > DW'(RELOAD_MIN))) ? wdata[CNT_W-1:0] : reload_q;
    clr      = wr_pend ? wdata[PEND_W-1:0] : '0;
    pend_d   = (pend_q & ~clr) | {alarm_set, expire};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pend_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      pend_q   <= pend_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             strobe,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    expire_o = 1'b0;
    if (start) begin
      cnt_d = reload;
      run_d = 1'b1;
    end else if (stop) begin
      run_d = 1'b0;
    end else if (run_q && strobe) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d    = reload;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 16,
  parameter int PRE_W = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_en,
  input  logic          alarm_set,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_tick,
  output logic          irq_alarm
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q, cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              start, stop, strobe, expire, running_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rtc_tick_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .src_en(src_en),
    .sel(ctrl_q[SEL_LSB +: SEL_W]), .strobe_o(strobe)
  );

  rtc_tick_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .alarm_set(alarm_set), .ctrl_o(ctrl_q),
    .reload_o(reload_q), .pend_o(pend_q), .start_o(start), .stop_o(stop)
  );

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .start(start), .stop(stop), .strobe(strobe),
    .reload(reload_q), .cnt_o(cnt_q), .running_o(running_q), .expire_o(expire)
  );

  always_comb begin
    unique case (addr)
      REG_PEND:   rdata = DW'(pend_q);
      REG_CTRL:   rdata = DW'(ctrl_q);
      REG_RELOAD: rdata = DW'(reload_q);
      default:    rdata = DW'(cnt_q);
    endcase
  end

  assign irq_tick  = pend_q[0];
  assign irq_alarm = pend_q[1];
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk #(
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [DW-1:0]    wdata,
  input logic             alarm_set,
  input logic             irq_tick,
  input logic             irq_alarm,
  input logic             strobe,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic [8:0]       ctrl
);
  logic wr_ctrl, wr_pend, wr_reload, due;
  assign wr_ctrl   = wr_en && (addr == 2'd1);
  assign wr_pend   = wr_en && (addr == 2'd0);
  assign wr_reload = wr_en && (addr == 2'd2);
  assign due       = running && strobe && (cnt <= CNT_W'(1));

  AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0) || (reload > CNT_W'(2))); // R2
  AST_RELOAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && (wdata <= DW'(2))) |=> $stable(reload)); // R2
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[0] && wdata[8] && !ctrl[8] && (reload != '0))
      |=> (running && (cnt == $past(reload)))); // R3
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !strobe && !wr_ctrl) |=> (running && $stable(cnt))); // R4
  AST_EXPIRE_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !wr_ctrl) |=> (irq_tick && (cnt == $past(reload)))); // R5
  AST_CLEAR_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && wdata[0] && !due) |=> !irq_tick); // R6
  AST_STOP_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl[0] && !wdata[0]) |=> !running); // R7
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_ctrl) |=> (!running && $stable(cnt))); // R7
  AST_ALARM_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_set |=> irq_alarm); // R8
endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .alarm_set(alarm_set), .irq_tick(irq_tick), .irq_alarm(irq_alarm),
  .strobe(strobe), .running(running_q), .cnt(cnt_q), .reload(reload_q),
  .ctrl(ctrl_q)
);

// File: tb/rtc_tick_timer_tb.sv
module rtc_tick_timer_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n, src_en, alarm_set, wr_en;
  logic [1:0]    addr;
  logic [DW-1:0] wdata, rdata;
  logic          irq_tick, irq_alarm;

  int tests = 0, fails = 0;
  int mk, mN, mR, mcnt, mpend, mrun;

  always #2.5 clk = ~clk;

  rtc_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .alarm_set(alarm_set),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_en = 1'b0; alarm_set = 1'b0; wr_en = 1'b0;
    addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mk = 0; mcnt = 0; mpend = 0; mrun = 0; mN = 0; mR = 0;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic pulse();
    @(negedge clk);
    src_en = 1'b1;
    @(negedge clk);
    src_en = 1'b0;
    mk++;
    if (mrun != 0 && (mk % (1 << mN)) == 0) begin
      if (mcnt <= 1) begin mcnt = mR; mpend = 1; end
      else mcnt--;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    do_reset();
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check(v == 0, "R1 reg after reset", v, 0);
    end
    check(irq_tick == 0 && irq_alarm == 0, "R1 irq after reset", irq_tick + irq_alarm, 0);

    // R2 reload floor
    for (int d = 0; d <= 2; d++) begin
      wr(2'd2, d); rd(2'd2, v); check(v == 0, "R2 small reload ignored", v, 0);
    end
    wr(2'd2, 3); rd(2'd2, v); check(v == 3, "R2 reload stored", v, 3);
    wr(2'd2, 2); rd(2'd2, v); check(v == 3, "R2 old reload kept", v, 3);

    // R3 no start without global enable, nor without a rising tick enable
    wr(2'd1, 32'h100);
    repeat (4) pulse();
    rd(2'd3, v); check(v == 0, "R3 no start with global off", v, 0);
    wr(2'd1, 32'h101);
    repeat (4) pulse();
    rd(2'd3, v); check(v == 0, "R3 no start without rising tick", v, 0);
    check(irq_tick == 0, "R3 no tick when idle", irq_tick, 0);
    wr(2'd1, 32'h001); wr(2'd1, 32'h101);
    rd(2'd3, v); check(v == 3, "R3 start loads reload", v, 3);

    // R3 zero reload blocks start
    do_reset();
    wr(2'd1, 32'h101);
    repeat (5) pulse();
    rd(2'd3, v); check(v == 0, "R3 zero reload no start", v, 0);
    check(irq_tick == 0, "R3 zero reload no tick", irq_tick, 0);

    // R7 stop by tick enable and by global enable
    do_reset();
    wr(2'd2, 5); wr(2'd1, 32'h101);
    repeat (2) pulse();
    rd(2'd3, v); check(v == 3, "R7 running before stop", v, 3);
    wr(2'd1, 32'h001);
    repeat (6) pulse();
    rd(2'd3, v); check(v == 3, "R7 tick-off holds count", v, 3);
    check(irq_tick == 0, "R7 no tick while stopped", irq_tick, 0);
    wr(2'd1, 32'h101);
    rd(2'd3, v); check(v == 5, "R3 restart reloads", v, 5);
    pulse();
    rd(2'd3, v); check(v == 4, "R4 step after restart", v, 4);
    wr(2'd1, 32'h000);
    repeat (6) pulse();
    rd(2'd3, v); check(v == 4, "R7 global-off holds count", v, 4);
    check(irq_tick == 0, "R7 no tick after global off", irq_tick, 0);

    // R8 / R6 alarm flag and selective clearing
    @(negedge clk); alarm_set = 1'b1; @(negedge clk); alarm_set = 1'b0;
    check(irq_alarm == 1, "R8 alarm irq", irq_alarm, 1);
    rd(2'd0, v); check(v == 2, "R8 pending bit1", v, 2);
    wr(2'd0, 0); check(irq_alarm == 1, "R6 zero write keeps alarm", irq_alarm, 1);
    wr(2'd0, 1); check(irq_alarm == 1, "R6 bit0 write keeps alarm", irq_alarm, 1);
    wr(2'd0, 2); check(irq_alarm == 0, "R6 bit1 write clears alarm", irq_alarm, 0);
    rd(2'd0, v); check(v == 0, "R6 pending empty", v, 0);

    // R4 R5 R6 R9 sweep over select and reload
    for (int n = 0; n < 4; n++) begin
      for (int ri = 0; ri < 4; ri++) begin
        int r;
        r = (ri == 0) ? 3 : (ri == 1) ? 4 : (ri == 2) ? 6 : 7;
        do_reset();
        wr(2'd2, r);
        wr(2'd1, 1 | (n << 4) | 32'h100);
        mN = n; mR = r; mcnt = r; mrun = 1;
        rd(2'd3, v); check(v == r, "R3 sweep start", v, r);
        for (int p = 0; p < 2 * r * (1 << n) + 2; p++) begin
          pulse();
          rd(2'd3, v); check(v == mcnt, "R4 R9 live count", v, mcnt);
          check(int'(irq_tick) == mpend, "R5 tick irq", irq_tick, mpend);
          if (mpend != 0) begin
            rd(2'd0, v); check(v == 1, "R5 pending bit0", v, 1);
            wr(2'd0, 1); mpend = 0;
            check(irq_tick == 0, "R6 tick cleared", irq_tick, 0);
          end
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule